// File: doc/BRIEF.md
# Packed Q15 Rounding Multiplier

This unit multiplies two 64-bit operands lane by lane. Each operand carries four signed 16-bit values, and each value is read as a Q15 fraction. For every lane pair the unit forms the full signed product. It adds half of one result LSB, shifts the sum right arithmetically by fifteen bits and keeps the low sixteen bits. The four lane results are packed back into one 64-bit word. The result is the rounded upper half of the fixed-point product, which fixed-point filters and gain stages use to scale samples without a bias toward minus infinity.

There is no back-pressure. A valid flag comes in with the operands and a valid flag goes out with the result. Each result appears exactly two clock cycles after its operands. Stage one registers the four products. Stage two rounds, shifts and packs, then registers the word. A new operation can start on every cycle. The result is never saturated: a lane that overflows wraps.

Top module: `q15_mulhrs_unit`

## Requirements
- R1: A synchronous active-high `rst` forces `out_valid` low on the cycle after any reset edge and clears all operations in flight. `in_valid` is ignored while `rst` is high.
- R2: `out_valid` equals the value `in_valid` had two rising edges earlier, with no reset in between. This holds when operations come back to back and when there are gaps between them.
- R3: For each lane i, result lane i = low 16 bits of ((a_i * b_i + 16384) >>> 15). The product is the full 32-bit signed product of the two 16-bit two's-complement lanes.
- R4: Lane i occupies bits [16*i+15 : 16*i] of `opnd_a`, `opnd_b` and `result`. Lane 0 is the least significant.
- R5: No saturation. -32768 * -32768 gives 16'h8000, and -32767 * -32767 gives 16'h7FFE.
- R6: Lanes are independent. Changing the operands of one lane leaves the other three result lanes unchanged.
- R7: A product that lies exactly halfway between two results rounds toward plus infinity. 3*16384 gives 2, -3*16384 gives -1, 1*16384 gives 1 and -1*16384 gives 0.
- R8: One operation is accepted on every cycle. Each of a run of consecutive operations returns its own correct result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| opnd_a | input | 64 | First packed operand, four signed 16-bit lanes |
| opnd_b | input | 64 | Second packed operand, four signed 16-bit lanes |
| out_valid | output | 1 | Result present this cycle |
| result | output | 64 | Packed rounded Q15 products |

## Verification
Two events can happen in the same cycle. A new operand pair can enter stage one while the previous pair is being rounded and packed in stage two. Reset can arrive while both stages hold valid work. The bench drives a stream of operations with gaps and some back-to-back runs. It checks every output word against a reference model that is two entries deep, so a stage-one register overwritten too early shows up as a wrong lane value. It also asserts reset while operations are in flight, keeps `in_valid` high during that reset, and requires `out_valid` to stay low until fresh operands have passed through both stages.

// File: rtl/q15_mul_pkg.sv
package q15_mul_pkg;
  localparam int unsigned Q_LANE_W = 16;
  localparam int unsigned Q_LANES  = 4;
  localparam int unsigned Q_DEPTH  = 2;

  // half of one result LSB, expressed at product scale
  function automatic int unsigned round_bias_exp(input int unsigned lane_w);
    return lane_w - 2;
  endfunction
endpackage

// File: rtl/q15_lane_prod.sv
module q15_lane_prod #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic                     clk,
  input  logic        [LANE_W-1:0] a_lane,
  input  logic        [LANE_W-1:0] b_lane,
  output logic signed [PROD_W-1:0] prod_q
);
  function automatic logic signed [PROD_W-1:0] full_product(
    input logic [LANE_W-1:0] x, input logic [LANE_W-1:0] y);
    logic signed [PROD_W-1:0] xs;
    logic signed [PROD_W-1:0] ys;
    xs = PROD_W'($signed(x));
    ys = PROD_W'($signed(y));
    return xs * ys;
  endfunction

  always_ff @(posedge clk) begin
    prod_q <= full_product(a_lane, b_lane);
  end
endmodule

// File: rtl/q15_lane_round.sv
module q15_lane_round #(
  parameter int unsigned LANE_W = 16,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic signed [PROD_W-1:0] prod,
  output logic        [LANE_W-1:0] lane_out
);
  import q15_mul_pkg::*;

  localparam logic signed [PROD_W-1:0] BIAS =
    PROD_W'(1) << round_bias_exp(LANE_W);

  // bits [PROD_W-2 : LANE_W-1] of the biased sum are the shifted, truncated lane
  function automatic logic [LANE_W-1:0] round_high(input logic signed [PROD_W-1:0] p);
    logic signed [PROD_W-1:0] biased;
    biased = p + BIAS;
    return biased[PROD_W-2:LANE_W-1];
  endfunction

  assign lane_out = round_high(prod);
endmodule

// File: rtl/q15_valid_pipe.sv
module q15_valid_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             v_in,
  output logic [DEPTH-1:0] v_stage
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic v_prev;
    if (s == 0) begin : g_head
      assign v_prev = v_in;
    end else begin : g_tail
      assign v_prev = v_stage[s-1];
    end
    always_ff @(posedge clk) begin
      if (rst) v_stage[s] <= 1'b0;
      else     v_stage[s] <= v_prev;
    end
  end
endmodule

// File: rtl/q15_mulhrs_unit.sv
module q15_mulhrs_unit #(
  parameter int unsigned LANE_W = q15_mul_pkg::Q_LANE_W,
  parameter int unsigned LANES  = q15_mul_pkg::Q_LANES,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  localparam int unsigned DEPTH = q15_mul_pkg::Q_DEPTH;

  logic [DEPTH-1:0]  v_stage;
  logic              stage1_valid;
  logic              stage2_valid;
  logic [WORD_W-1:0] packed_next;

  q15_valid_pipe #(.DEPTH(DEPTH)) u_vpipe (
    .clk     (clk),
    .rst     (rst),
    .v_in    (in_valid),
    .v_stage (v_stage)
  );

  assign stage1_valid = v_stage[0];
  assign stage2_valid = v_stage[DEPTH-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] prod_q;
    logic        [LANE_W-1:0] lane_res;

    q15_lane_prod #(.LANE_W(LANE_W)) u_prod (
      .clk    (clk),
      .a_lane (opnd_a[l*LANE_W +: LANE_W]),
      .b_lane (opnd_b[l*LANE_W +: LANE_W]),
      .prod_q (prod_q)
    );

    q15_lane_round #(.LANE_W(LANE_W)) u_round (
      .prod     (prod_q),
      .lane_out (lane_res)
    );

    assign packed_next[l*LANE_W +: LANE_W] = lane_res;
  end

  always_ff @(posedge clk) begin
    result <= packed_next;
  end

  assign out_valid = stage2_valid;
endmodule

// File: rtl/q15_mulhrs_chk.sv
module q15_mulhrs_chk #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned WORD_W = LANE_W * LANES,
  localparam int unsigned PROD_W = 2 * LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] opnd_a,
  input logic [WORD_W-1:0] opnd_b,
  input logic              stage1_valid,
  input logic              out_valid,
  input logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] a_d1, a_d2, b_d1, b_d2;
  logic              rst_seen = 1'b0;

  always_ff @(posedge clk) begin
    a_d1 <= opnd_a; a_d2 <= a_d1;
    b_d1 <= opnd_b; b_d2 <= b_d1;
    rst_seen <= rst;
  end

  // R1
  always @(posedge clk) begin
    if (rst_seen) begin
      reset_clear_chk: assert (!out_valid) else $error("out_valid high after reset");
    end
  end

  // R2
  accept_stage_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> stage1_valid);

  // R2
  emit_stage_chk: assert property (@(posedge clk) disable iff (rst)
    stage1_valid |=> out_valid);

  // R2
  bubble_stage_chk: assert property (@(posedge clk) disable iff (rst)
    !stage1_valid |=> !out_valid);

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    logic signed [LANE_W-1:0] xa, xb;
    logic signed [PROD_W:0]   ref_sum;
    logic        [LANE_W-1:0] ref_lane;
    assign xa = a_d2[l*LANE_W +: LANE_W];
    assign xb = b_d2[l*LANE_W +: LANE_W];
    assign ref_sum  = ((PROD_W+1)'(xa) * (PROD_W+1)'(xb)) + ((PROD_W+1)'(1) << (LANE_W-2));
    assign ref_lane = LANE_W'(ref_sum >>> (LANE_W-1));

    // R3
    lane_value_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> result[l*LANE_W +: LANE_W] == ref_lane);
  end

  // R5
  wrap_min_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && a_d2[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}}
               && b_d2[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}})
    |-> result[LANE_W-1:0] == {1'b1, {(LANE_W-1){1'b0}}});
endmodule

bind q15_mulhrs_unit q15_mulhrs_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .opnd_a       (opnd_a),
  .opnd_b       (opnd_b),
  .stage1_valid (stage1_valid),
  .out_valid    (out_valid),
  .result       (result)
);

// File: tb/test_q15_mulhrs_unit.sv
module test_q15_mulhrs_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  // {opnd_a, opnd_b, expected}
  localparam logic [191:0] VEC [NVEC] = '{
    {64'h8001_3DA9_0105_A312, 64'h8001_209D_AEF6_4000, 64'h7FFE_0FB6_FF5B_D189},
    {64'h7FFF_FFFF_0001_8000, 64'h7FFF_4000_4000_8000, 64'h7FFE_0000_0001_8000},
    {64'hFFFF_0100_1234_7FFF, 64'hFFFF_0100_0000_8000, 64'h0000_0002_0000_8001},
    {64'h8001_7000_0105_A312, 64'h8001_7000_AEF6_4000, 64'h7FFE_6200_FF5B_D189}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        hv [2];
  logic [63:0] he [2];
  string       ht [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  q15_mulhrs_unit i_q15_mulhrs_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    for (int l = 0; l < 4; l++) begin
      int p;
      p = int'($signed(a[16*l +: 16])) * int'($signed(b[16*l +: 16]));
      p = (p + 16384) >>> 15;
      r[16*l +: 16] = p[15:0];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: judge what left the pipe, then drive the next operation
  task automatic step(input string tag, input logic v, input logic [63:0] a,
                      input logic [63:0] b, input logic [63:0] e);
    @(negedge clk);
    check("R2", {63'd0, out_valid}, {63'd0, hv[1]});
    if (hv[1]) check(ht[1], result, he[1]);
    hv[1] = hv[0]; he[1] = he[0]; ht[1] = ht[0];
    hv[0] = v;     he[0] = e;     ht[0] = tag;
    in_valid = v; opnd_a = a; opnd_b = b;
  endtask

  task automatic flush();
    repeat (2) step("R2", 1'b0, '0, '0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    hv[0] = 1'b0; hv[1] = 1'b0;
    he[0] = '0;   he[1] = '0;
    ht[0] = "";   ht[1] = "";
    in_valid = 1'b1;  // R1: ignored while in reset
    repeat (3) @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);

    // table walk: R3, R4 (lane order), R5 (wrap), R6 (one lane changed vs vector 0)
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      case (i)
        0: tag = "R4";
        1: tag = "R5";
        2: tag = "R3";
        default: tag = "R6";
      endcase
      step(tag, 1'b1, VEC[i][191:128], VEC[i][127:64], VEC[i][63:0]);
    end
    flush();

    // R7 half-way products
    step("R7", 1'b1, 64'hFFFD_0003_FFFF_0001, 64'h4000_4000_4000_4000,
         64'hFFFF_0002_0000_0001);
    flush();

    // R8 back-to-back stream with occasional bubbles
    begin
      logic [63:0] sa = 64'h1357_9BDF_2468_ACE0;
      logic [63:0] sb = 64'hFEDC_BA98_7654_3210;
      for (int k = 0; k < 40; k++) begin
        logic v;
        sa = {sa[62:0], sa[63] ^ sa[62] ^ sa[60] ^ sa[59]};
        sb = {sb[62:0], sb[63] ^ sb[61] ^ sb[59] ^ sb[58]} ^ 64'(k);
        v = (k % 7) != 5;
        step("R8", v, sa, sb, model(sa, sb));
      end
      flush();
    end

    // R1 reset with both stages full and in_valid held high
    step("R8", 1'b1, VEC[0][191:128], VEC[0][127:64], VEC[0][63:0]);
    step("R8", 1'b1, VEC[1][191:128], VEC[1][127:64], VEC[1][63:0]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    hv[0] = 1'b0; hv[1] = 1'b0;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    step("R3", 1'b1, VEC[2][191:128], VEC[2][127:64], VEC[2][63:0]);
    flush();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule